// File: doc/BRIEF.md
# Gated Edge Frequency Counter

This block measures the rate of a digital signal. It counts the signal's rising edges during a gate window, and the length of that window is set by a reference timebase. A mode input picks the timebase. In normal counting mode, a reference tick stream is divided by five. In the alternate timing mode, a second tick stream is used directly. A three-bit resolution code picks how many timebase ticks the window lasts. The counted value is the edge count during the window, so the frequency is that count divided by the window length.

All logic runs on one system clock. The measured signal is brought in through a two-stage synchronizer. Its rising edges are detected in the system clock domain. Each edge advances an 8-bit prefix counter. A carry out of the prefix advances a high-order counter. The high-order counter has its own wrap detection, which sets a sticky overflow interrupt. When the window closes, a completion interrupt is raised. A processor-side command port starts a window and acknowledges each interrupt on its own. Two read strobes return the prefix count or the high count.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, `busy`, `irq_done` and `irq_ovf` are 0 and `rd_data` is 0.
- R2: With `mode_alt` = 0, the timebase ticks once every five `ref_tick` pulses, so a window of N timebase ticks keeps `busy` high for 5·N cycles (±2) when `ref_tick` is held at 1.
- R3: With `mode_alt` = 1, every `alt_tick` pulse is a timebase tick, so a window of N ticks keeps `busy` high for N cycles (±2) when `alt_tick` is held at 1.
- R4: The window length N in timebase ticks is set by `res_code`. Code 0 gives 100·GATE_BASE, code 1 gives 10·GATE_BASE, and codes 2 to 7 give GATE_BASE.
- R5: Rising edges of `sig_in` are counted only while `busy` is 1. Edges that arrive after the window closes leave both count values unchanged.
- R6: The total count is hi·256 + lo. The 8-bit prefix wraps from 255 to 0, and at that wrap the high counter advances by one.
- R7: A write with `cmd_bits[0]` = 1 clears both counters and restarts the prescaler and the window. This holds even if a window is already open.
- R8: When a window closes, `irq_done` goes to 1 and stays there until it is acknowledged.
- R9: When the high counter wraps from all ones, `irq_ovf` goes to 1 and the high counter continues from 0. `irq_ovf` stays at 1 until it is acknowledged, and a start command does not clear it.
- R10: A write with `cmd_bits[1]` = 1 clears `irq_done`, and a write with `cmd_bits[2]` = 1 clears `irq_ovf`. Each acknowledge leaves the other flag untouched.
- R11: A pulse on `rd_lo` loads `rd_data` with the zero-extended prefix count on the next cycle. A pulse on `rd_hi` loads it with the zero-extended high count. The counts hold until the next start.

Verification section and port table follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick stream, divided by five in counting mode |
| alt_tick | input | 1 | Alternate timebase tick stream, used directly |
| mode_alt | input | 1 | 0 selects the divided reference, 1 selects the alternate ticks |
| res_code | input | 3 | Resolution code that sets the window length |
| sig_in | input | 1 | Signal being measured (asynchronous) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 3 | Bit 0 is start, bit 1 acknowledges completion, bit 2 acknowledges overflow |
| rd_lo | input | 1 | Read strobe for the prefix count |
| rd_hi | input | 1 | Read strobe for the high count |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | High while the gate window is open |
| irq_done | output | 1 | Sticky window-complete interrupt |
| irq_ovf | output | 1 | Sticky high-counter overflow interrupt |

## Verification
Different internal faults show up in different ways at the ports:
- A prescaler or gate-length fault changes how long `busy` stays high. The bench sees this within the same window, because it counts every cycle that `busy` is high.
- A fault in edge gating, carry or clearing gives wrong `rd_data` values. These appear at the first read after the window closes. Extra edges sent after the close expose any leak in the gating.
- Flag faults show up on `irq_done` and `irq_ovf` in the cycle after the close, the wrap or the acknowledge. The bench therefore sends each acknowledge on its own and then looks at both lines.

// File: rtl/fc_pkg.sv
package fc_pkg;

  localparam int unsigned RES_W = 3;

  typedef enum logic [RES_W-1:0] {
    RES_COARSE  = 3'd0,
    RES_MEDIUM  = 3'd1,
    RES_FINE_A  = 3'd2,
    RES_FINE_B  = 3'd3,
    RES_FINE_C  = 3'd4,
    RES_FINE_D  = 3'd5
  } res_e;

  // Window length in timebase ticks for a resolution code.
  function automatic int unsigned window_ticks(input logic [RES_W-1:0] code,
                                               input int unsigned base);
    case (code)
      3'd0:    window_ticks = 100 * base;
      3'd1:    window_ticks = 10 * base;
      default: window_ticks = base;
    endcase
  endfunction

endpackage

// File: rtl/fc_timebase.sv
module fc_timebase #(
  parameter int unsigned PRESCALE = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic mode_alt,
  input  logic ref_tick,
  input  logic alt_tick,
  output logic tb_tick
);
  localparam int unsigned PC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);

  logic [PC_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc      <= '0;
      tb_tick <= 1'b0;
    end else begin
      tb_tick <= 1'b0;
      if (mode_alt) begin
        tb_tick <= alt_tick;
      end else if (ref_tick) begin
        if (pc == PC_LAST) begin
          pc      <= '0;
          tb_tick <= 1'b1;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

  // R2
  tb_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (PRESCALE > 1 && tb_tick && !mode_alt && !clr) |=> !tb_tick);

endmodule

// File: rtl/fc_gate.sv
module fc_gate #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tb_tick,
  input  logic [CNT_W-1:0] win_len,
  output logic             gate_open,
  output logic             close_pulse
);
  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_open   <= 1'b0;
      close_pulse <= 1'b0;
      tick_cnt    <= '0;
    end else begin
      close_pulse <= 1'b0;
      if (start) begin
        gate_open <= 1'b1;
        tick_cnt  <= '0;
      end else if (gate_open && tb_tick) begin
        if (tick_cnt == win_len - 1'b1) begin
          gate_open   <= 1'b0;
          close_pulse <= 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  // R8
  gate_close_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_open) |-> close_pulse);

  // R7
  gate_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> gate_open);

endmodule

// File: rtl/fc_edge_count.sv
module fc_edge_count #(
  parameter int unsigned HI_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            enable,
  input  logic            sig_in,
  output logic [7:0]      lo_cnt,
  output logic [HI_W-1:0] hi_cnt,
  output logic            ovf_pulse
);
  logic s1, s2, s3;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sig_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= 1'b0;
      if (enable && rise) begin
        lo_cnt <= lo_cnt + 1'b1;
        if (lo_cnt == 8'hFF) begin
          hi_cnt <= hi_cnt + 1'b1;
          if (&hi_cnt) ovf_pulse <= 1'b1;
        end
      end
    end
  end

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clr) |=> ($stable(lo_cnt) && $stable(hi_cnt)));

  // R6
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && rise && !clr && lo_cnt == 8'hFF) |=>
      (lo_cnt == 8'h00 && hi_cnt == HI_W'($past(hi_cnt) + 1'b1)));

  // R9
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (hi_cnt == '0));

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
  parameter int unsigned GATE_BASE = 4000,
  parameter int unsigned PRESCALE  = 5,
  parameter int unsigned HI_W      = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ref_tick,
  input  logic        alt_tick,
  input  logic        mode_alt,
  input  logic [2:0]  res_code,
  input  logic        sig_in,
  input  logic        cmd_wr,
  input  logic [2:0]  cmd_bits,
  input  logic        rd_lo,
  input  logic        rd_hi,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        irq_done,
  output logic        irq_ovf
);
  import fc_pkg::*;

  localparam int unsigned CNT_W = $clog2(100 * GATE_BASE + 1);

  logic             start_cmd, ack_done, ack_ovf;
  logic             tb_tick;
  logic             gate_open, close_pulse;
  logic [7:0]       lo_cnt;
  logic [HI_W-1:0]  hi_cnt;
  logic             ovf_pulse;
  logic [CNT_W-1:0] win_len;

  assign start_cmd = cmd_wr & cmd_bits[0];
  assign ack_done  = cmd_wr & cmd_bits[1];
  assign ack_ovf   = cmd_wr & cmd_bits[2];
  assign win_len   = CNT_W'(window_ticks(res_code, GATE_BASE));
  assign busy      = gate_open;

  fc_timebase #(.PRESCALE(PRESCALE)) u_tb (
    .clk(clk), .rst(rst), .clr(start_cmd), .mode_alt(mode_alt),
    .ref_tick(ref_tick), .alt_tick(alt_tick), .tb_tick(tb_tick)
  );

  fc_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst(rst), .start(start_cmd), .tb_tick(tb_tick),
    .win_len(win_len), .gate_open(gate_open), .close_pulse(close_pulse)
  );

  fc_edge_count #(.HI_W(HI_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(start_cmd), .enable(gate_open),
    .sig_in(sig_in), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .ovf_pulse(ovf_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_done <= 1'b0;
      irq_ovf  <= 1'b0;
    end else begin
      if (close_pulse)   irq_done <= 1'b1;
      else if (ack_done) irq_done <= 1'b0;
      if (ovf_pulse)     irq_ovf  <= 1'b1;
      else if (ack_ovf)  irq_ovf  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_lo) begin
      rd_data <= {8'h00, lo_cnt};
    end else if (rd_hi) begin
      rd_data <= 16'(hi_cnt);
    end
  end

  // R10
  ack_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_done && !ack_ovf && !ovf_pulse) |=> (irq_ovf == $past(irq_ovf)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ovf && !ack_ovf) |=> irq_ovf);

  // R8
  done_after_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_done) |-> $past(busy, 2));

endmodule

// File: tb/sim_gated_freq_counter.sv
module sim_gated_freq_counter;
  localparam int unsigned BASE = 60;
  localparam int unsigned HIW  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b1, alt_tick = 1'b1, mode_alt = 1'b0;
  logic [2:0]  res_code = 3'd2;
  logic        sig_in = 1'b0, cmd_wr = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [2:0]  cmd_bits = 3'd0;
  logic [15:0] rd_data;
  logic        busy, irq_done, irq_ovf;

  int checks = 0, fails = 0;
  bit finished = 0;

  gated_freq_counter #(.GATE_BASE(BASE), .PRESCALE(5), .HI_W(HIW)) u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .alt_tick(alt_tick),
    .mode_alt(mode_alt), .res_code(res_code), .sig_in(sig_in),
    .cmd_wr(cmd_wr), .cmd_bits(cmd_bits), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_data(rd_data), .busy(busy), .irq_done(irq_done), .irq_ovf(irq_ovf)
  );

  always #5 clk = ~clk;

  function automatic int ticks_for(input int res);
    if (res == 0) return 100 * BASE;
    if (res == 1) return 10 * BASE;
    return BASE;
  endfunction

  function automatic int exp_busy(input int md, input int res);
    return md ? ticks_for(res) : 5 * ticks_for(res);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act < exp - tol || act > exp + tol) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] b);
    @(negedge clk); cmd_wr = 1'b1; cmd_bits = b;
    @(negedge clk); cmd_wr = 1'b0; cmd_bits = 3'd0;
  endtask

  task automatic read_cnt(output int lo, output int hi);
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); rd_lo = 1'b0; lo = int'(rd_data); rd_hi = 1'b1;
    @(negedge clk); rd_hi = 1'b0; hi = int'(rd_data);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sig_in = 1'b1;
      @(negedge clk);
      @(negedge clk); sig_in = 1'b0;
      @(negedge clk);
    end
  endtask

  // Starts a window and sends k pulses inside it; returns busy cycles.
  task automatic run_window(input int md, input int res, input int k, output int bcyc);
    int cyc;
    mode_alt = md[0];
    res_code = res[2:0];
    cmd(3'b001);
    cyc = 0; bcyc = 0;
    while (busy && cyc < 40000) begin
      sig_in = (cyc >= 8 && (cyc - 8) / 4 < k && ((cyc - 8) % 4) < 2);
      bcyc++; cyc++;
      @(negedge clk);
    end
    sig_in = 1'b0;
    if (cyc >= 40000) begin
      fails++;
      $display("FAIL watchdog: window never closed");
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic verify_count(input string req, input int k);
    int lo, hi;
    read_cnt(lo, hi);
    check({req, " lo"}, lo, k % 256);
    check({req, " hi"}, hi, (k / 256) % (1 << HIW));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int bc, lo, hi, md, res, k, win;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 irq_done", int'(irq_done), 0);
    check("R1 irq_ovf", int'(irq_ovf), 0);
    check("R1 rd_data", int'(rd_data), 0);

    // R2 R4 divided reference, fine code
    run_window(0, 2, 20, bc);
    check_near("R2 busy length code2", bc, exp_busy(0, 2), 2);
    verify_count("R5 count", 20);
    check("R8 irq_done", int'(irq_done), 1);

    // R5 edges after close ignored
    pulses(6);
    repeat (4) @(negedge clk);
    verify_count("R5 post-window hold", 20);

    // R10 ack ovf leaves done set, ack done clears
    cmd(3'b100);
    check("R10 done kept", int'(irq_done), 1);
    cmd(3'b010);
    check("R10 done cleared", int'(irq_done), 0);

    // R3 R4 alternate ticks
    run_window(1, 1, 100, bc);
    check_near("R3 busy length code1", bc, exp_busy(1, 1), 2);
    check_near("R4 code5 equals base", exp_busy(1, 5), BASE, 0);
    verify_count("R3 count", 100);

    // R6 carry into high counter
    run_window(0, 1, 300, bc);
    check_near("R4 busy length code1", bc, exp_busy(0, 1), 2);
    verify_count("R6 carry", 300);

    // R7 restart clears an open window
    mode_alt = 1'b0; res_code = 3'd1;
    cmd(3'b001);
    pulses(5);
    read_cnt(lo, hi);
    check("R11 live read lo", lo, 5);
    run_window(0, 2, 3, bc);
    verify_count("R7 restart", 3);

    // R9 overflow and sticky flag
    cmd(3'b010);
    run_window(0, 0, 4100, bc);
    check_near("R4 busy length code0", bc, exp_busy(0, 0), 2);
    verify_count("R9 wrap", 4100);
    check("R9 irq_ovf", int'(irq_ovf), 1);
    cmd(3'b001);
    repeat (2) @(negedge clk);
    check("R9 start keeps ovf", int'(irq_ovf), 1);
    read_cnt(lo, hi);
    check("R7 cleared lo", lo, 0);
    check("R7 cleared hi", hi, 0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    cmd(3'b010);
    check("R10 ovf kept", int'(irq_ovf), 1);
    check("R10 done acked", int'(irq_done), 0);
    cmd(3'b100);
    check("R10 ovf cleared", int'(irq_ovf), 0);

    // random windows
    for (int it = 0; it < 8; it++) begin
      md  = int'($urandom % 2);
      res = 1 + int'($urandom % 5);
      win = exp_busy(md, res);
      k   = int'($urandom % ((win - 20) / 4 + 1));
      run_window(md, res, k, bc);
      check_near("R4 random busy", bc, win, 2);
      verify_count("R6 random count", k);
      check("R8 random done", int'(irq_done), 1);
      cmd(3'b010);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule